// File: doc/BRIEF.md
# Activity-Based Thermal Domain Estimator

This block produces a power and temperature estimate for one thermal domain without an analog sensor. On each evaluation tick it takes a snapshot of a bank of digital activity counters together with per-counter weights, the domain's voltage and frequency codes, an I/O offset, and the temperature estimates and coupling weights of the neighbouring domains. It computes a weighted switching capacitance and scales it by voltage squared times frequency to get dynamic power. It then adds a static term from a small computed table indexed by voltage and by the previous temperature estimate. All sums saturate.

The power figure drives a first-order discrete thermal filter that models the cooling path as a rise above ambient. A fixed worst-case ambient, the I/O offset and the weighted neighbour contribution are added to the filter state to form the temperature estimate. The same inputs always give the same result, whatever the real environment. A power-management controller reads both estimates when the one-cycle valid strobe fires and uses them to pick the next operating point.

Top module: `act_thermal_est`

## Requirements
- R1: After reset, estValid is 0, powerEst is 0, tempEst equals AMBIENT (180), and the filter rise state is 0.
- R2: The capacitance is cac = sum over i of actWeight[i]*actCnt[i]. Dynamic power is floor(cac*vCode*vCode*fCode / 2^DYN_SH), with DYN_SH = 14, saturated at 4095.
- R3: Static power is STAT_UNIT*(vIdx+1)*(tIdx+1), with STAT_UNIT = 8. Here vIdx is vCode[5:4] and tIdx is bits [9:8] of the tempEst value present before the tick. powerEst = min(dynamic + static, 4095).
- R4: The filter target is floor(powerEst*3/16). The rise state updates as rise += floor((target - rise)/4), rounding toward minus infinity, so it heats and cools with the same step rule.
- R5: tempEst = min(180 + rise + ioOffset + floor((nbrWeight[0]*nbrTemp[0] + nbrWeight[1]*nbrTemp[1]) / 16), 1023), using the rise value just updated.
- R6: If evalTick is sampled high at clock edge k, powerEst and tempEst update at edge k+4 and estValid is high for exactly the following cycle. The outputs hold their values at all other times.
- R7: A tick that arrives while an estimate is in progress (edges k+1 to k+4) is ignored. It produces no second valid pulse and does not change the result.
- R8: All inputs are sampled only at the tick edge. Changing them during the estimate has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evalTick | input | 1 | Starts one estimate when idle |
| actCnt | input | 4x10 | Activity counts per monitor |
| actWeight | input | 4x6 | Capacitance weight per monitor |
| vCode | input | 6 | Voltage code |
| fCode | input | 6 | Frequency code |
| ioOffset | input | 8 | Additive temperature offset |
| nbrTemp | input | 2x10 | Neighbour domain temperature estimates |
| nbrWeight | input | 2x4 | Coupling weight per neighbour |
| powerEst | output | 12 | Power estimate |
| tempEst | output | 10 | Temperature estimate |
| estValid | output | 1 | One-cycle strobe when a new estimate is present |

## Verification
The hardest situation to reach is a change of static power caused by the block's own earlier result. The static term depends on the previous temperature estimate crossing a 256-unit boundary, and only a long run of heavy activity can push the filter there. The stimulus applies saturated activity over many consecutive ticks until the estimate crosses several boundaries. It then removes all activity so that the rise decays with negative steps. The bench tracks the filter state tick by tick from the requirement formulas.

// File: rtl/ate_pkg.sv
package ate_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_DYN  = 3'd1,
    S_POW  = 3'd2,
    S_FILT = 3'd3,
    S_TEMP = 3'd4
  } ateState_t;

  typedef struct packed {
    logic capture;
    logic doDyn;
    logic doPow;
    logic doFilt;
    logic doTemp;
  } ateStrb_t;

endpackage

// File: rtl/ate_ctrl.sv
module ate_ctrl
  import ate_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     evalTick,
  output ateStrb_t strb,
  output logic     estValid
);

  ateState_t state, nxtState;

  always_comb begin
    nxtState = state;
    unique case (state)
      S_IDLE:  nxtState = evalTick ? S_DYN : S_IDLE;
      S_DYN:   nxtState = S_POW;
      S_POW:   nxtState = S_FILT;
      S_FILT:  nxtState = S_TEMP;
      S_TEMP:  nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  always_comb begin
    strb.capture = (state == S_IDLE) && evalTick;
    strb.doDyn   = (state == S_DYN);
    strb.doPow   = (state == S_POW);
    strb.doFilt  = (state == S_FILT);
    strb.doTemp  = (state == S_TEMP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      estValid <= 1'b0;
    end else begin
      state    <= nxtState;
      estValid <= strb.doTemp;
    end
  end

  // R6: valid lasts one cycle
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    estValid |=> !estValid);

  // R6: valid follows the capture by a fixed latency
  assert_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    estValid |-> $past(strb.capture, 5));

  // R7: no new capture while an estimate is running
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> !strb.capture && (state == S_DYN));

endmodule

// File: rtl/ate_datapath.sv
module ate_datapath
  import ate_pkg::*;
#(
  parameter int NUM_MON   = 4,
  parameter int CNT_W     = 10,
  parameter int WGT_W     = 6,
  parameter int V_W       = 6,
  parameter int F_W       = 6,
  parameter int P_W       = 12,
  parameter int T_W       = 10,
  parameter int OFF_W     = 8,
  parameter int NUM_NBR   = 2,
  parameter int NW_W      = 4,
  parameter int DYN_SH    = 14,
  parameter int VIDX_W    = 2,
  parameter int TIDX_W    = 2,
  parameter int STAT_UNIT = 8,
  parameter int RTH_W     = 4,
  parameter int RTH_NUM   = 3,
  parameter int RTH_SH    = 4,
  parameter int ALPHA_SH  = 2,
  parameter int NBR_SH    = 4,
  parameter int AMBIENT   = 180
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  ateStrb_t                           strb,
  input  logic [NUM_MON-1:0][CNT_W-1:0]      actCnt,
  input  logic [NUM_MON-1:0][WGT_W-1:0]      actWeight,
  input  logic [V_W-1:0]                     vCode,
  input  logic [F_W-1:0]                     fCode,
  input  logic [OFF_W-1:0]                   ioOffset,
  input  logic [NUM_NBR-1:0][T_W-1:0]        nbrTemp,
  input  logic [NUM_NBR-1:0][NW_W-1:0]       nbrWeight,
  output logic [P_W-1:0]                     powerEst,
  output logic [T_W-1:0]                     tempEst
);

  localparam int CAC_W  = CNT_W + WGT_W + $clog2(NUM_MON + 1);
  localparam int PROD_W = CAC_W + 2 * V_W + F_W;
  localparam int STAT_N = 2 ** (VIDX_W + TIDX_W);
  localparam int TGT_W  = P_W + RTH_W;
  localparam int NS_W   = NW_W + T_W + $clog2(NUM_NBR + 1);
  localparam int SUMT_W = TGT_W + NS_W;
  localparam logic [P_W-1:0]    P_MAX    = {P_W{1'b1}};
  localparam logic [PROD_W-1:0] P_MAX_W  = PROD_W'(P_MAX);
  localparam logic [T_W-1:0]    T_MAX    = {T_W{1'b1}};
  localparam logic [SUMT_W-1:0] T_MAX_W  = SUMT_W'(T_MAX);
  localparam logic [TGT_W-1:0]  RISE_MAX = TGT_W'((TGT_W'(P_MAX) * TGT_W'(RTH_NUM)) >> RTH_SH);

  typedef logic [STAT_N-1:0][P_W-1:0] statTbl_t;

  function automatic statTbl_t buildStat();
    statTbl_t tbl;
    for (int vi = 0; vi < 2 ** VIDX_W; vi++) begin
      for (int ti = 0; ti < 2 ** TIDX_W; ti++) begin
        tbl[vi * (2 ** TIDX_W) + ti] = P_W'(STAT_UNIT * (vi + 1) * (ti + 1));
      end
    end
    return tbl;
  endfunction

  localparam statTbl_t STAT_TBL = buildStat();

  // Weighted capacitance from the live inputs, captured at the tick
  logic [NUM_MON-1:0][CAC_W-1:0] monProd;
  logic [CAC_W-1:0]              cacNow;

  genvar g;
  generate
    for (g = 0; g < NUM_MON; g++) begin : gMon
      assign monProd[g] = CAC_W'(actCnt[g]) * CAC_W'(actWeight[g]);
    end
  endgenerate

  always_comb begin
    cacNow = '0;
    for (int i = 0; i < NUM_MON; i++) cacNow = cacNow + monProd[i];
  end

  // Neighbour coupling
  logic [NUM_NBR-1:0][NS_W-1:0] nbrProd;
  logic [NS_W-1:0]              nbrSum;

  generate
    for (g = 0; g < NUM_NBR; g++) begin : gNbr
      assign nbrProd[g] = NS_W'(nbrTemp[g]) * NS_W'(nbrWeight[g]);
    end
  endgenerate

  always_comb begin
    nbrSum = '0;
    for (int j = 0; j < NUM_NBR; j++) nbrSum = nbrSum + nbrProd[j];
  end

  // Captured operands and pipeline registers
  logic [CAC_W-1:0] cacR;
  logic [V_W-1:0]   vR;
  logic [F_W-1:0]   fR;
  logic [OFF_W-1:0] offR;
  logic [NS_W-1:0]  nbrAddR;
  logic [P_W-1:0]   dynR;
  logic [P_W-1:0]   powR;
  logic [TGT_W-1:0] riseR;

  // Dynamic power
  logic [PROD_W-1:0] dynFull, dynSh;
  logic [P_W-1:0]    dynSat;
  always_comb begin
    dynFull = PROD_W'(cacR) * PROD_W'(vR) * PROD_W'(vR) * PROD_W'(fR);
    dynSh   = dynFull >> DYN_SH;
    dynSat  = (dynSh > P_MAX_W) ? P_MAX : dynSh[P_W-1:0];
  end

  // Static power from the computed table
  logic [VIDX_W-1:0]        vIdx;
  logic [TIDX_W-1:0]        tIdx;
  logic [P_W-1:0]           statPw;
  logic [P_W:0]             powSum;
  logic [P_W-1:0]           powSat;
  always_comb begin
    vIdx   = vR[V_W-1 -: VIDX_W];
    tIdx   = tempEst[T_W-1 -: TIDX_W];
    statPw = STAT_TBL[{vIdx, tIdx}];
    powSum = {1'b0, dynR} + {1'b0, statPw};
    powSat = powSum[P_W] ? P_MAX : powSum[P_W-1:0];
  end

  // First-order thermal filter on the rise above ambient
  logic [TGT_W-1:0]        target;
  logic signed [TGT_W:0]   diff, step;
  logic [TGT_W-1:0]        riseNext;
  always_comb begin
    target   = TGT_W'((TGT_W'(powR) * TGT_W'(RTH_NUM)) >> RTH_SH);
    diff     = $signed({1'b0, target}) - $signed({1'b0, riseR});
    step     = diff >>> ALPHA_SH;
    riseNext = TGT_W'($signed({1'b0, riseR}) + step);
  end

  // Temperature assembly
  logic [SUMT_W-1:0] tSum;
  logic [T_W-1:0]    tSat;
  always_comb begin
    tSum = SUMT_W'(AMBIENT) + SUMT_W'(riseR) + SUMT_W'(offR) + SUMT_W'(nbrAddR);
    tSat = (tSum > T_MAX_W) ? T_MAX : tSum[T_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cacR     <= '0;
      vR       <= '0;
      fR       <= '0;
      offR     <= '0;
      nbrAddR  <= '0;
      dynR     <= '0;
      powR     <= '0;
      riseR    <= '0;
      powerEst <= '0;
      tempEst  <= T_W'(AMBIENT);
    end else begin
      if (strb.capture) begin
        cacR    <= cacNow;
        vR      <= vCode;
        fR      <= fCode;
        offR    <= ioOffset;
        nbrAddR <= nbrSum >> NBR_SH;
      end
      if (strb.doDyn)  dynR  <= dynSat;
      if (strb.doPow)  powR  <= powSat;
      if (strb.doFilt) riseR <= riseNext;
      if (strb.doTemp) begin
        powerEst <= powR;
        tempEst  <= tSat;
      end
    end
  end

  // R6: estimates change only on the publish step
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.doTemp |=> $stable(tempEst) && $stable(powerEst));

  // R3: power never falls below the smallest static entry
  assert_pow_floor_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doPow |=> powR >= STAT_TBL[0]);

  // R4: filter state stays within the largest target
  assert_rise_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    riseR <= RISE_MAX);

  // R5: temperature never drops below ambient
  assert_temp_floor_R5: assert property (@(posedge clk) disable iff (!rstN)
    tempEst >= T_W'(AMBIENT));

endmodule

// File: rtl/act_thermal_est.sv
module act_thermal_est
  import ate_pkg::*;
#(
  parameter int NUM_MON = 4,
  parameter int CNT_W   = 10,
  parameter int WGT_W   = 6,
  parameter int V_W     = 6,
  parameter int F_W     = 6,
  parameter int P_W     = 12,
  parameter int T_W     = 10,
  parameter int OFF_W   = 8,
  parameter int NUM_NBR = 2,
  parameter int NW_W    = 4,
  parameter int AMBIENT = 180
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          evalTick,
  input  logic [NUM_MON-1:0][CNT_W-1:0] actCnt,
  input  logic [NUM_MON-1:0][WGT_W-1:0] actWeight,
  input  logic [V_W-1:0]                vCode,
  input  logic [F_W-1:0]                fCode,
  input  logic [OFF_W-1:0]              ioOffset,
  input  logic [NUM_NBR-1:0][T_W-1:0]   nbrTemp,
  input  logic [NUM_NBR-1:0][NW_W-1:0]  nbrWeight,
  output logic [P_W-1:0]                powerEst,
  output logic [T_W-1:0]                tempEst,
  output logic                          estValid
);

  ateStrb_t strb;

  ate_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .evalTick (evalTick),
    .strb     (strb),
    .estValid (estValid)
  );

  ate_datapath #(
    .NUM_MON (NUM_MON),
    .CNT_W   (CNT_W),
    .WGT_W   (WGT_W),
    .V_W     (V_W),
    .F_W     (F_W),
    .P_W     (P_W),
    .T_W     (T_W),
    .OFF_W   (OFF_W),
    .NUM_NBR (NUM_NBR),
    .NW_W    (NW_W),
    .AMBIENT (AMBIENT)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .actCnt    (actCnt),
    .actWeight (actWeight),
    .vCode     (vCode),
    .fCode     (fCode),
    .ioOffset  (ioOffset),
    .nbrTemp   (nbrTemp),
    .nbrWeight (nbrWeight),
    .powerEst  (powerEst),
    .tempEst   (tempEst)
  );

endmodule

// File: tb/sim_act_thermal_est.sv
module sim_act_thermal_est;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evalTick = 1'b0;
  logic [3:0][9:0] actCnt = '0;
  logic [3:0][5:0] actWeight = '0;
  logic [5:0] vCode = '0;
  logic [5:0] fCode = '0;
  logic [7:0] ioOffset = '0;
  logic [1:0][9:0] nbrTemp = '0;
  logic [1:0][3:0] nbrWeight = '0;
  logic [11:0] powerEst;
  logic [9:0] tempEst;
  logic estValid;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  // model state
  int mA[4];
  int mW[4];
  int mV, mF, mOff;
  int mNt[2];
  int mNw[2];
  int mRise = 0;
  int mTemp = 180;
  int mPow = 0;

  always #2 clk = ~clk;

  act_thermal_est u0 (
    .clk(clk), .rstN(rstN), .evalTick(evalTick),
    .actCnt(actCnt), .actWeight(actWeight), .vCode(vCode), .fCode(fCode),
    .ioOffset(ioOffset), .nbrTemp(nbrTemp), .nbrWeight(nbrWeight),
    .powerEst(powerEst), .tempEst(tempEst), .estValid(estValid)
  );

  task automatic check(string tag, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic modelStep();
    longint cac, dyn;
    int stat, tgt, d, t;
    cac = 0;
    for (int i = 0; i < 4; i++) cac += longint'(mA[i]) * mW[i];
    dyn = (cac * mV * mV * mF) >> 14;
    if (dyn > 4095) dyn = 4095;
    stat = 8 * ((mV >> 4) + 1) * ((mTemp >> 8) + 1);
    mPow = int'(dyn) + stat;
    if (mPow > 4095) mPow = 4095;
    tgt = (mPow * 3) >> 4;
    d = tgt - mRise;
    mRise = mRise + (d >>> 2);
    t = 180 + mRise + mOff + ((mNw[0] * mNt[0] + mNw[1] * mNt[1]) >> 4);
    if (t > 1023) t = 1023;
    mTemp = t;
  endtask

  task automatic drive();
    for (int i = 0; i < 4; i++) begin
      actCnt[i] = 10'(mA[i]);
      actWeight[i] = 6'(mW[i]);
    end
    vCode = 6'(mV);
    fCode = 6'(mF);
    ioOffset = 8'(mOff);
    for (int j = 0; j < 2; j++) begin
      nbrTemp[j] = 10'(mNt[j]);
      nbrWeight[j] = 4'(mNw[j]);
    end
  endtask

  // One estimate: inputs scrambled after the tick edge (R8); optional busy tick (R7)
  task automatic runTick(string tag, bit busyTick);
    int prevP, prevT, seen;
    @(negedge clk);
    drive();
    evalTick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    evalTick = 1'b0;
    for (int i = 0; i < 4; i++) begin
      actCnt[i] = 10'(1023 - mA[i]);
      actWeight[i] = 6'(63 - mW[i]);
    end
    vCode = ~vCode; fCode = ~fCode; ioOffset = ~ioOffset;
    nbrTemp = ~nbrTemp; nbrWeight = ~nbrWeight;
    modelStep();
    seen = 0;
    for (int k = 1; k <= 3; k++) begin
      if (busyTick && k == 1) evalTick = 1'b1;
      @(posedge clk);
      @(negedge clk);
      evalTick = 1'b0;
      if (estValid) seen++;
    end
    check("R6", {tag, " early valid"}, seen, 0);
    @(posedge clk);
    @(negedge clk);
    check("R6", {tag, " valid"}, int'(estValid), 1);
    check("R3", {tag, " power"}, int'(powerEst), mPow);
    check("R5", {tag, " temp"}, int'(tempEst), mTemp);
    prevP = int'(powerEst);
    prevT = int'(tempEst);
    seen = 0;
    for (int k = 0; k < (busyTick ? 6 : 1); k++) begin
      @(posedge clk);
      @(negedge clk);
      if (estValid) seen++;
    end
    check(busyTick ? "R7" : "R6", {tag, " valid after"}, seen, 0);
    check("R6", {tag, " hold"}, int'(powerEst == 12'(prevP) && tempEst == 10'(prevT)), 1);
  endtask

  task automatic setPattern(int a0, int a1, int a2, int a3, int w0, int w1, int w2, int w3,
                            int v, int f, int off, int nt0, int nt1, int nw0, int nw1);
    mA[0] = a0; mA[1] = a1; mA[2] = a2; mA[3] = a3;
    mW[0] = w0; mW[1] = w1; mW[2] = w2; mW[3] = w3;
    mV = v; mF = f; mOff = off;
    mNt[0] = nt0; mNt[1] = nt1; mNw[0] = nw0; mNw[1] = nw1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "valid", int'(estValid), 0);
    check("R1", "power", int'(powerEst), 0);
    check("R1", "temp", int'(tempEst), 180);
  endtask

  task automatic t_basic();
    setPattern(10, 20, 30, 40, 1, 2, 3, 4, 32, 32, 0, 0, 0, 0, 0);
    runTick("R2 basic", 1'b0);
    check("R2", "basic power value", int'(powerEst), 624);
    check("R4", "first rise temp", int'(tempEst), 209);
  endtask

  task automatic t_zeroFreq();
    setPattern(500, 500, 500, 500, 63, 63, 63, 63, 48, 0, 0, 0, 0, 0, 0);
    runTick("R2 zero freq", 1'b0);
  endtask

  task automatic t_heat();
    setPattern(1023, 1023, 1023, 1023, 63, 63, 63, 63, 63, 63, 0, 0, 0, 0, 0);
    for (int n = 0; n < 14; n++) runTick("R4 heat", 1'b0);
    check("R3", "heated past tIdx boundary", int'(tempEst >= 10'd512), 1);
  endtask

  task automatic t_cool();
    setPattern(0, 0, 0, 0, 0, 0, 0, 0, 5, 10, 0, 0, 0, 0, 0);
    for (int n = 0; n < 14; n++) runTick("R4 cool", 1'b0);
  endtask

  task automatic t_neighbour();
    setPattern(100, 0, 50, 7, 9, 0, 20, 63, 40, 20, 20, 300, 400, 5, 3);
    runTick("R5 neighbour", 1'b0);
  endtask

  task automatic t_tempSat();
    setPattern(1023, 1023, 1023, 1023, 63, 63, 63, 63, 63, 63, 255, 1023, 1023, 15, 15);
    runTick("R5 saturate", 1'b0);
    check("R5", "temp saturated", int'(tempEst), 1023);
  endtask

  task automatic t_busy();
    setPattern(200, 300, 100, 50, 10, 5, 2, 40, 30, 25, 3, 0, 0, 0, 0);
    runTick("R7 busy tick", 1'b1);
  endtask

  task automatic t_capture();
    setPattern(60, 70, 80, 90, 11, 22, 33, 44, 20, 50, 7, 250, 120, 2, 9);
    runTick("R8 capture", 1'b0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_basic();
    t_zeroFreq();
    t_heat();
    t_cool();
    t_neighbour();
    t_tempSat();
    t_busy();
    t_capture();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule